// File: doc/BRIEF.md
# Trip-Zone Input Conditioner

This block sits between a set of external active-low fault pins and the PWM modules that shut down on a fault. For each pin it offers three paths to the PWM side: a direct combinational pass-through with no added delay, a two-flop synchronizer into the peripheral clock domain, or that synchronizer followed by a persistence filter. The filter accepts a new level only after the level has held for six clock cycles. It suppresses short spikes on noisy lines.

Each pin has its own three-bit path selector. The selector is decoded by priority and registered, so a path change takes effect at the next rising clock edge. After reset every pin uses the pass-through path, so a fault reaches the PWM modules before any clock runs. The number of pins, the synchronizer depth and the filter length are parameters. The defaults are three pins, two stages and six cycles.

Top module: `trip_cond`

## Requirements
- R1: While reset is asserted, every lane uses the pass-through path. The synchronizer flops and the filtered level reset high, so in the first cycle after reset a lane switched to the synchronized path outputs 1.
- R2: Lane i uses select field path_sel[3i+2:3i]. The field is decoded by priority: bit 0 set selects pass-through. Otherwise bit 1 set selects synchronized. Otherwise bit 2 set selects filtered. An all-zero field selects synchronized.
- R3: On the pass-through path, trip_n_out[i] equals trip_n_raw[i] combinationally, within the same cycle.
- R4: On the synchronized path, trip_n_out[i] equals the raw level sampled two rising edges earlier.
- R5: On the filtered path, a raw level first sampled at rising edge A and held through edge A+5 appears on the output right after edge A+7.
- R6: On the filtered path, a raw level held for five sampling edges or fewer leaves the output unchanged.
- R7: A new select value is taken at the next rising edge. Until that edge the lane keeps its previous path.
- R8: While the filtered path is not selected, its stored level follows the synchronized copy and its count stays at zero. When the filtered path is selected again, counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock for the synchronizers, filters and select registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_n_raw | input | N_TRIP | Raw active-low fault pins, one per lane |
| path_sel | input | 3*N_TRIP | Per-lane path select fields, three bits per lane |
| trip_n_out | output | N_TRIP | Conditioned active-low fault signals toward the PWM modules |

## Verification
The clocked properties treat the raw pins and select fields as levels that are stable around every rising edge. Without that, a pass-through output compared at the edge and a synchronizer sample cannot be related cycle by cycle. The stimulus changes every input only at the falling clock edge, never near the sampling edge. This holds for both the random phase and the directed cases. The property on filter persistence also assumes the filtered path has been selected continuously for a window longer than two filter lengths. The random phase changes selectors rarely enough that such windows occur often.

// File: rtl/tzc_pkg.sv
package tzc_pkg;

    typedef enum logic [1:0] {
        TZ_ASYNC = 2'd0,
        TZ_SYNC  = 2'd1,
        TZ_FILT  = 2'd2
    } tz_mode_e;

    // Priority decode of a three-bit path select field
    function automatic tz_mode_e tz_decode(input logic [2:0] sel);
        tz_mode_e m;
        if (sel[0])      m = TZ_ASYNC;
        else if (sel[1]) m = TZ_SYNC;
        else if (sel[2]) m = TZ_FILT;
        else             m = TZ_SYNC;
        return m;
    endfunction

endpackage

// File: rtl/tzc_sync.sv
module tzc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pipe: '1};
        else        st_q <= st_d;
    end

    assign q = st_q.pipe[STAGES-1];
endmodule

// File: rtl/tzc_filter.sv
module tzc_filter #(
    parameter int HOLD = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic din,
    output logic dout
);
    localparam int CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             level;
    } filt_state_t;

    filt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            // idle: track the input, keep the count cleared
            st_d.level = din;
            st_d.cnt   = '0;
        end else if (din != st_q.level) begin
            if (st_q.cnt == LAST) begin
                st_d.level = din;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, level: 1'b1};
        else        st_q <= st_d;
    end

    assign dout = st_q.level;
endmodule

// File: rtl/tzc_lane.sv
module tzc_lane
    import tzc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 6
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     raw_n,
    input  logic [2:0] sel,
    output logic     trip_n_o,
    output tz_mode_e mode_o
);
    typedef struct packed {
        tz_mode_e mode;
    } lane_state_t;

    lane_state_t st_d, st_q;
    logic        sync_n;
    logic        filt_n;

    always_comb begin
        st_d      = st_q;
        st_d.mode = tz_decode(sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: TZ_ASYNC};
        else        st_q <= st_d;
    end

    tzc_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_n),
        .q    (sync_n)
    );

    tzc_filter #(.HOLD(FILT_CYCLES)) i_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (st_q.mode == TZ_FILT),
        .din  (sync_n),
        .dout (filt_n)
    );

    always_comb begin
        case (st_q.mode)
            TZ_ASYNC: trip_n_o = raw_n;
            TZ_FILT:  trip_n_o = filt_n;
            default:  trip_n_o = sync_n;
        endcase
    end

    assign mode_o = st_q.mode;
endmodule

// File: rtl/trip_cond.sv
module trip_cond
    import tzc_pkg::*;
#(
    parameter int N_TRIP      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYCLES = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_TRIP-1:0]     trip_n_raw,
    input  logic [3*N_TRIP-1:0]   path_sel,
    output logic [N_TRIP-1:0]     trip_n_out
);
    localparam int SEL_W = 3;

    logic [2*N_TRIP-1:0] lane_mode_flat;

    for (genvar g = 0; g < N_TRIP; g++) begin : g_lane
        tz_mode_e mode_g;

        tzc_lane #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_CYCLES(FILT_CYCLES)
        ) i_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_n   (trip_n_raw[g]),
            .sel     (path_sel[SEL_W*g +: SEL_W]),
            .trip_n_o(trip_n_out[g]),
            .mode_o  (mode_g)
        );

        assign lane_mode_flat[2*g +: 2] = mode_g;
    end
endmodule

// File: rtl/trip_cond_chk.sv
module trip_cond_chk #(
    parameter int N_TRIP      = 3,
    parameter int FILT_CYCLES = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_TRIP-1:0]   trip_n_raw,
    input logic [3*N_TRIP-1:0] path_sel,
    input logic [N_TRIP-1:0]   trip_n_out,
    input logic [2*N_TRIP-1:0] lane_mode
);
    localparam logic [7:0] WIN  = 8'(2*FILT_CYCLES + 4);
    localparam logic [7:0] MINH = 8'(FILT_CYCLES - 1);

    logic [1:0] since_rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  since_rst_q <= '0;
        else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
    end

    for (genvar g = 0; g < N_TRIP; g++) begin : g_chk
        logic [1:0] md;
        logic [7:0] run_q;
        logic [7:0] held_q;
        logic       prev_q;

        assign md = lane_mode[2*g +: 2];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                run_q  <= '0;
                held_q <= '0;
                prev_q <= 1'b1;
            end else begin
                prev_q <= trip_n_out[g];
                if (md != 2'(tzc_pkg::TZ_FILT)) run_q <= '0;
                else if (run_q != 8'hFF)          run_q <= run_q + 8'd1;
                if (trip_n_out[g] != prev_q)      held_q <= '0;
                else if (held_q != 8'hFF)         held_q <= held_q + 8'd1;
            end
        end

        // R1: pass-through while in reset
        p_reset_async_r1: assert property (@(posedge clk)
            !rst_n |-> trip_n_out[g] == trip_n_raw[g]);

        // R2, R7: select decoded and taken at the next edge
        p_decode_async_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst_q != 2'd0 && $past(path_sel[3*g]))
            |-> md == 2'(tzc_pkg::TZ_ASYNC));
        p_decode_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst_q != 2'd0 && $past(path_sel[3*g +: 2]) == 2'b10)
            |-> md == 2'(tzc_pkg::TZ_SYNC));
        p_decode_filt_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst_q != 2'd0 && $past(path_sel[3*g +: 3]) == 3'b100)
            |-> md == 2'(tzc_pkg::TZ_FILT));

        // R3: pass-through path
        p_async_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
            md == 2'(tzc_pkg::TZ_ASYNC) |-> trip_n_out[g] == trip_n_raw[g]);

        // R4: two-edge synchronizer latency
        p_sync_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst_q >= 2'd2 && md == 2'(tzc_pkg::TZ_SYNC))
            |-> trip_n_out[g] == $past(trip_n_raw[g], 2));

        // R6: filtered output keeps each level for at least the filter length
        p_filt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (run_q >= WIN && md == 2'(tzc_pkg::TZ_FILT) && trip_n_out[g] != prev_q)
            |-> held_q >= MINH);
    end
endmodule

bind trip_cond trip_cond_chk #(
    .N_TRIP     (N_TRIP),
    .FILT_CYCLES(FILT_CYCLES)
) i_trip_cond_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trip_n_raw(trip_n_raw),
    .path_sel  (path_sel),
    .trip_n_out(trip_n_out),
    .lane_mode (lane_mode_flat)
);

// File: tb/test_trip_cond.sv
module test_trip_cond;
    localparam int N = 3;
    localparam int F = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   raw = '1;
    logic [3*N-1:0] sel = '0;
    logic [N-1:0]   out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    trip_cond i_trip_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .trip_n_raw(raw),
        .path_sel  (sel),
        .trip_n_out(out)
    );

    always #5 clk = ~clk;

    // ---------------- reference model (from the requirements) ----------------
    // mode: 0 pass-through, 1 synchronized, 2 filtered
    int   m_mode [N];
    logic m_s1   [N];
    logic m_s2   [N];
    logic m_f    [N];
    int   m_c    [N];

    function automatic int dec(input logic [2:0] s);
        if (s[0]) return 0;
        if (s[1]) return 1;
        if (s[2]) return 2;
        return 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                m_mode[i] <= 0; m_s1[i] <= 1'b1; m_s2[i] <= 1'b1;
                m_f[i] <= 1'b1; m_c[i] <= 0;
            end else begin
                m_mode[i] <= dec(sel[3*i +: 3]);
                m_s1[i]   <= raw[i];
                m_s2[i]   <= m_s1[i];
                if (m_mode[i] != 2) begin
                    m_f[i] <= m_s2[i]; m_c[i] <= 0;
                end else if (m_s2[i] != m_f[i]) begin
                    if (m_c[i] == F - 1) begin m_f[i] <= m_s2[i]; m_c[i] <= 0; end
                    else m_c[i] <= m_c[i] + 1;
                end else m_c[i] <= 0;
            end
        end
    end

    function automatic logic exp_bit(input int i);
        if (!rst_n || m_mode[i] == 0) return raw[i];
        if (m_mode[i] == 2) return m_f[i];
        return m_s2[i];
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_model(input string tag);
        for (int i = 0; i < N; i++) begin
            string t;
            if (tag != "") t = tag;
            else if (m_mode[i] == 0) t = "R3";
            else if (m_mode[i] == 1) t = "R4";
            else t = (m_c[i] != 0) ? "R6" : "R5";
            chk(t, out[i], exp_bit(i));
        end
    endtask

    task automatic nclk(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(2_000_000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'h5EED_7A11));

        // R1: pass-through during reset
        raw = 3'b010; sel = '0;
        nclk(2);
        chk("R1", out[0], 1'b0); chk("R1", out[1], 1'b1); chk("R1", out[2], 1'b0);
        raw = 3'b000;
        #1 chk("R1", out[1], 1'b0);
        // R1: synchronizer resets high, lanes go synchronized (all-zero field)
        rst_n = 1'b1;
        nclk(1);
        for (int i = 0; i < N; i++) chk("R1", out[i], 1'b1);
        nclk(2);
        for (int i = 0; i < N; i++) chk("R4", out[i], 1'b0);

        // R2: priority decode across fields
        raw = '1;
        sel = {3'b100, 3'b110, 3'b111};
        nclk(12);
        raw = 3'b000;
        #1;
        chk("R2", out[0], 1'b0);
        chk("R2", out[1], 1'b1);
        chk("R2", out[2], 1'b1);
        nclk(2);
        chk("R2", out[1], 1'b0);
        chk("R2", out[2], 1'b1);
        sel = {3'b000, 3'b011, 3'b010};
        raw = '1;
        nclk(1);
        chk("R2", out[1], 1'b1);
        chk("R2", out[0], 1'b0);
        chk("R2", out[2], 1'b0);
        nclk(2);
        chk_model("R2");

        // R5: six-edge persistence on lane 2
        sel = {3'b100, 3'b010, 3'b010};
        raw = '1;
        nclk(12);
        raw[2] = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            nclk(1);
            chk("R5", out[2], (k < 8) ? 1'b1 : 1'b0);
        end
        raw[2] = 1'b1;
        nclk(12);
        chk("R5", out[2], 1'b1);

        // R6: five-edge pulse is rejected
        raw[2] = 1'b0;
        nclk(5);
        raw[2] = 1'b1;
        for (int k = 0; k < 10; k++) begin
            chk("R6", out[2], 1'b1);
            nclk(1);
        end

        // R7: select change waits for the next edge
        sel[2:0] = 3'b000;
        raw[0] = 1'b0;
        nclk(5);
        raw[0] = 1'b1;
        sel[2:0] = 3'b001;
        #1 chk("R7", out[0], 1'b0);
        nclk(1);
        chk("R7", out[0], 1'b1);

        // R8: filter deselected then reselected mid-count
        sel[5:3] = 3'b100;
        raw[1] = 1'b1;
        nclk(12);
        raw[1] = 1'b0;
        nclk(5);
        chk_model("R8");
        sel[5:3] = 3'b010;
        nclk(1);
        chk_model("R8");
        sel[5:3] = 3'b100;
        raw[1] = 1'b1;
        for (int k = 0; k < 12; k++) begin
            nclk(1);
            chk_model("R8");
        end

        // random phase against the model
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            chk_model("");
            for (int i = 0; i < N; i++) begin
                if ($urandom_range(0, 7) == 0) raw[i] = ~raw[i];
                if ($urandom_range(0, 59) == 0) sel[3*i +: 3] = 3'($urandom_range(0, 7));
            end
            #1 chk_model("R7");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule